// File: doc/BRIEF.md
# Program Counter and Stack Sequencer

This block owns the 16-bit program counter and the 8-bit stack pointer of a small 8-bit controller core. For every control-flow instruction the decoder hands it a class code, the instruction length in bytes and the operand fields (relative offset, 11-bit and 16-bit absolute addresses, the branch-taken flag, the accumulator, the data pointer and, for a push, the byte to be stored). The block works out the next program counter and moves the stack pointer.

Calls, returns, pushes and pops also need the internal data RAM. The block drives a byte-wide port with one access per clock, and a return address is split across two bytes. The RAM read port has one cycle of latency. `busy` stays high while a stack sequence is running. During that time the program counter and stack pointer hold their values and new issue requests are ignored. The stack grows upward. A push increments the pointer before it writes. A pop reads before it decrements. A return address goes in with its low byte first, at the lower address.

Top module: `pc_stack_seq`

## Requirements
- R1: After reset, `pc` is 0000h, `sp` is 07h, `busy` is 0 and neither `ram_we` nor `ram_re` is asserted.
- R2: Class 0 (sequential) sets `pc` to `pc + instr_len`, wrapping modulo 65536; the new value is visible after the issuing clock edge.
- R3: Class 1 (short relative jump) and class 5 (conditional branch with `taken` = 1) set `pc` to `pc + instr_len + sign_extend(rel_off)`. Class 5 with `taken` = 0 sets `pc` to `pc + instr_len`. All of these wrap modulo 65536.
- R4: Class 2 (absolute jump) keeps `pc[15:11]` and replaces `pc[10:0]` with `abs_addr11`.
- R5: Class 3 (long jump) loads `pc` with `abs_addr16`.
- R6: Class 4 (indirect jump) loads `pc` with `dptr + acc`, wrapping modulo 65536.
- R7: Class 6 (short call, target formed as in R4) and class 7 (long call, target `abs_addr16`) take two busy cycles. The first cycle writes the low byte of `pc + instr_len` to address `sp+1`. The second cycle writes the high byte to `sp+2`. When the sequence ends, `sp` has risen by 2 and `pc` holds the target.
- R8: Class 8 (return) takes three busy cycles. It reads address `sp` (high byte) and then address `sp-1` (low byte); read data returns one cycle after `ram_re`. At the end `pc` is {high, low} and `sp` has dropped by 2.
- R9: Class 9 (push) takes one busy cycle. That cycle writes `push_data` to `sp+1`. At the end `sp` has risen by 1 and `pc` is `pc + instr_len`.
- R10: Class 10 (pop) takes two busy cycles and reads address `sp`. At the end `pop_data` holds the byte that was read, `pop_valid` is high for exactly one cycle, `sp` has dropped by 1 and `pc` is `pc + instr_len`.
- R11: While `busy` is high, `pc` and `sp` do not change. A `start` seen while `busy` is high has no effect.
- R12: The stack pointer wraps modulo 256 on both increment and decrement, and no error is raised.
- R13: `ram_we` and `ram_re` are never asserted in the same cycle, and neither is asserted while `busy` is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Active-low synchronous reset |
| start | input | 1 | Issue strobe for one instruction |
| op_class | input | 4 | Control-flow class code (0 to 10) |
| instr_len | input | 2 | Instruction length in bytes |
| rel_off | input | 8 | Signed relative offset |
| abs_addr11 | input | 11 | Short absolute target |
| abs_addr16 | input | 16 | Long absolute target |
| taken | input | 1 | Branch condition result |
| acc | input | 8 | Accumulator value |
| dptr | input | 16 | Data pointer value |
| push_data | input | 8 | Byte to push |
| ram_rdata | input | 8 | RAM read data, one cycle after `ram_re` |
| ram_we | output | 1 | RAM write strobe |
| ram_re | output | 1 | RAM read strobe |
| ram_addr | output | 8 | RAM byte address |
| ram_wdata | output | 8 | RAM write data |
| pc | output | 16 | Program counter |
| sp | output | 8 | Stack pointer |
| busy | output | 1 | Stack sequence in progress |
| pop_data | output | 8 | Byte returned by the last pop |
| pop_valid | output | 1 | One-cycle pulse when `pop_data` is updated |

## Verification
The target logic is checked with a chain of jumps in which each result becomes the base of the next one. Positive and negative offsets tell sign extension apart from zero extension. An offset of 80h and targets that cross FFFFh expose carries lost at the top bit. A base with nonzero upper bits shows whether an absolute jump splices the low 11 bits into the current address or zero-fills the rest. The stack is tested with a nested call and return pair mixing the short and long forms, which separates low-first from high-first byte order and the two return lengths. A run of pops from the reset pointer, followed by a push, passes through the 00h/FFh boundary, and a `start` raised in the middle of a push shows whether issue is blocked while the block is busy.

// File: rtl/pcs_pkg.sv
package pcs_pkg;

   typedef enum logic [3:0] {
      CLS_SEQ    = 4'd0,
      CLS_SREL   = 4'd1,
      CLS_ABS    = 4'd2,
      CLS_LONG   = 4'd3,
      CLS_IND    = 4'd4,
      CLS_BRANCH = 4'd5,
      CLS_SCALL  = 4'd6,
      CLS_LCALL  = 4'd7,
      CLS_RET    = 4'd8,
      CLS_PUSH   = 4'd9,
      CLS_POP    = 4'd10
   } op_cls_e;

   typedef enum logic [3:0] {
      ST_IDLE,
      ST_CALL_LO,
      ST_CALL_HI,
      ST_RET_HI,
      ST_RET_LO,
      ST_RET_END,
      ST_PUSH_WR,
      ST_POP_RD,
      ST_POP_END
   } seq_st_e;

   function automatic logic uses_stack(input op_cls_e c);
      return (c == CLS_SCALL) || (c == CLS_LCALL) || (c == CLS_RET) ||
             (c == CLS_PUSH)  || (c == CLS_POP);
   endfunction

endpackage

// File: rtl/pcs_target.sv
module pcs_target
   import pcs_pkg::*;
#(
   parameter int PC_W  = 16,
   parameter int ABS_W = 11,
   parameter int OFF_W = 8,
   parameter int LEN_W = 2,
   parameter int ACC_W = 8
) (
   input  logic [PC_W-1:0]  cur_pc,
   input  op_cls_e          cls,
   input  logic [LEN_W-1:0] len,
   input  logic [OFF_W-1:0] off,
   input  logic [ABS_W-1:0] abs_s,
   input  logic [PC_W-1:0]  abs_l,
   input  logic             taken,
   input  logic [ACC_W-1:0] acc,
   input  logic [PC_W-1:0]  dptr,
   output logic [PC_W-1:0]  next_pc,
   output logic [PC_W-1:0]  ret_pc
);

   localparam int EXT_W = PC_W - OFF_W;

   logic [PC_W-1:0] seq_pc;
   logic [PC_W-1:0] rel_pc;
   logic [PC_W-1:0] splice_pc;
   logic [PC_W-1:0] ind_pc;

   assign seq_pc = cur_pc + PC_W'(len);
   assign rel_pc = seq_pc + {{EXT_W{off[OFF_W-1]}}, off};
   assign ind_pc = dptr + PC_W'(acc);

   generate
      if (ABS_W >= PC_W) begin : g_full_abs
         assign splice_pc = abs_s[PC_W-1:0];
      end else begin : g_splice_abs
         assign splice_pc = {cur_pc[PC_W-1:ABS_W], abs_s};
      end
   endgenerate

   assign ret_pc = seq_pc;

   always_comb begin
      unique case (cls)
         CLS_SREL:              next_pc = rel_pc;
         CLS_ABS, CLS_SCALL:    next_pc = splice_pc;
         CLS_LONG, CLS_LCALL:   next_pc = abs_l;
         CLS_IND:               next_pc = ind_pc;
         CLS_BRANCH:            next_pc = taken ? rel_pc : seq_pc;
         default:               next_pc = seq_pc;
      endcase
   end

endmodule

// File: rtl/pcs_stack_fsm.sv
module pcs_stack_fsm
   import pcs_pkg::*;
#(
   parameter int DW     = 8,
   parameter int SPW    = 8,
   parameter int PCW    = 16,
   parameter logic [SPW-1:0] SP_RST = 8'h07
) (
   input  logic            clk,
   input  logic            rst_n,
   input  logic            accept,
   input  op_cls_e         cls,
   input  logic [PCW-1:0]  ret_pc,
   input  logic [PCW-1:0]  tgt_pc,
   input  logic [DW-1:0]   push_data,
   input  logic [DW-1:0]   ram_rdata,
   output logic            ram_we,
   output logic            ram_re,
   output logic [SPW-1:0]  ram_addr,
   output logic [DW-1:0]   ram_wdata,
   output logic [SPW-1:0]  sp,
   output logic            busy,
   output logic            pc_upd,
   output logic [PCW-1:0]  pc_upd_val,
   output logic [DW-1:0]   pop_data,
   output logic            pop_valid
);

   localparam logic [SPW-1:0] STEP1 = SPW'(1);
   localparam logic [SPW-1:0] STEP2 = SPW'(2);

   seq_st_e         st;
   logic [PCW-1:0]  ret_q;
   logic [PCW-1:0]  tgt_q;
   logic [DW-1:0]   dat_q;
   logic [DW-1:0]   hi_q;

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         st        <= ST_IDLE;
         sp        <= SP_RST;
         ret_q     <= '0;
         tgt_q     <= '0;
         dat_q     <= '0;
         hi_q      <= '0;
         pop_data  <= '0;
         pop_valid <= 1'b0;
      end else begin
         pop_valid <= 1'b0;
         unique case (st)
            ST_IDLE: begin
               if (accept) begin
                  ret_q <= ret_pc;
                  tgt_q <= tgt_pc;
                  dat_q <= push_data;
                  unique case (cls)
                     CLS_SCALL, CLS_LCALL: st <= ST_CALL_LO;
                     CLS_RET:              st <= ST_RET_HI;
                     CLS_PUSH:             st <= ST_PUSH_WR;
                     CLS_POP:              st <= ST_POP_RD;
                     default:              st <= ST_IDLE;
                  endcase
               end
            end
            ST_CALL_LO: st <= ST_CALL_HI;
            ST_CALL_HI: begin
               sp <= sp + STEP2;
               st <= ST_IDLE;
            end
            ST_RET_HI:  st <= ST_RET_LO;
            ST_RET_LO: begin
               hi_q <= ram_rdata;
               st   <= ST_RET_END;
            end
            ST_RET_END: begin
               sp <= sp - STEP2;
               st <= ST_IDLE;
            end
            ST_PUSH_WR: begin
               sp <= sp + STEP1;
               st <= ST_IDLE;
            end
            ST_POP_RD:  st <= ST_POP_END;
            ST_POP_END: begin
               pop_data  <= ram_rdata;
               pop_valid <= 1'b1;
               sp        <= sp - STEP1;
               st        <= ST_IDLE;
            end
            default:    st <= ST_IDLE;
         endcase
      end
   end

   always_comb begin
      ram_we     = 1'b0;
      ram_re     = 1'b0;
      ram_addr   = sp;
      ram_wdata  = '0;
      pc_upd     = 1'b0;
      pc_upd_val = tgt_q;
      unique case (st)
         ST_CALL_LO: begin
            ram_we    = 1'b1;
            ram_addr  = sp + STEP1;
            ram_wdata = ret_q[DW-1:0];
         end
         ST_CALL_HI: begin
            ram_we    = 1'b1;
            ram_addr  = sp + STEP2;
            ram_wdata = ret_q[PCW-1:DW];
            pc_upd    = 1'b1;
         end
         ST_RET_HI: begin
            ram_re   = 1'b1;
            ram_addr = sp;
         end
         ST_RET_LO: begin
            ram_re   = 1'b1;
            ram_addr = sp - STEP1;
         end
         ST_RET_END: begin
            pc_upd     = 1'b1;
            pc_upd_val = {hi_q, ram_rdata};
         end
         ST_PUSH_WR: begin
            ram_we    = 1'b1;
            ram_addr  = sp + STEP1;
            ram_wdata = dat_q;
            pc_upd    = 1'b1;
         end
         ST_POP_RD: begin
            ram_re   = 1'b1;
            ram_addr = sp;
         end
         ST_POP_END: pc_upd = 1'b1;
         default: ;
      endcase
   end

   assign busy = (st != ST_IDLE);

endmodule

// File: rtl/pc_stack_seq.sv
module pc_stack_seq
   import pcs_pkg::*;
#(
   parameter int DW     = 8,
   parameter int PC_W   = 16,
   parameter int SP_W   = 8,
   parameter int ABS_W  = 11,
   parameter int LEN_W  = 2,
   parameter logic [PC_W-1:0] PC_RST = 16'h0000,
   parameter logic [SP_W-1:0] SP_RST = 8'h07
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              start,
   input  logic [3:0]        op_class,
   input  logic [LEN_W-1:0]  instr_len,
   input  logic [DW-1:0]     rel_off,
   input  logic [ABS_W-1:0]  abs_addr11,
   input  logic [PC_W-1:0]   abs_addr16,
   input  logic              taken,
   input  logic [DW-1:0]     acc,
   input  logic [PC_W-1:0]   dptr,
   input  logic [DW-1:0]     push_data,
   input  logic [DW-1:0]     ram_rdata,
   output logic              ram_we,
   output logic              ram_re,
   output logic [SP_W-1:0]   ram_addr,
   output logic [DW-1:0]     ram_wdata,
   output logic [PC_W-1:0]   pc,
   output logic [SP_W-1:0]   sp,
   output logic              busy,
   output logic [DW-1:0]     pop_data,
   output logic              pop_valid
);

   generate
      if (PC_W != 2 * DW) begin : g_bad_pc_w
         $error("PC_W must be twice DW: return address is stored as two bytes");
      end
      if (ABS_W > PC_W) begin : g_bad_abs_w
         $error("ABS_W must not exceed PC_W");
      end
      if (SP_W < 2) begin : g_bad_sp_w
         $error("SP_W too small");
      end
   endgenerate

   op_cls_e         cls;
   logic            accept;
   logic [PC_W-1:0] next_pc;
   logic [PC_W-1:0] ret_pc;
   logic            pc_upd;
   logic [PC_W-1:0] pc_upd_val;

   assign cls    = op_cls_e'(op_class);
   assign accept = start && !busy;

   pcs_target #(
      .PC_W  (PC_W),
      .ABS_W (ABS_W),
      .OFF_W (DW),
      .LEN_W (LEN_W),
      .ACC_W (DW)
   ) u_target (
      .cur_pc  (pc),
      .cls     (cls),
      .len     (instr_len),
      .off     (rel_off),
      .abs_s   (abs_addr11),
      .abs_l   (abs_addr16),
      .taken   (taken),
      .acc     (acc),
      .dptr    (dptr),
      .next_pc (next_pc),
      .ret_pc  (ret_pc)
   );

   pcs_stack_fsm #(
      .DW     (DW),
      .SPW    (SP_W),
      .PCW    (PC_W),
      .SP_RST (SP_RST)
   ) u_stack (
      .clk        (clk),
      .rst_n      (rst_n),
      .accept     (accept),
      .cls        (cls),
      .ret_pc     (ret_pc),
      .tgt_pc     (next_pc),
      .push_data  (push_data),
      .ram_rdata  (ram_rdata),
      .ram_we     (ram_we),
      .ram_re     (ram_re),
      .ram_addr   (ram_addr),
      .ram_wdata  (ram_wdata),
      .sp         (sp),
      .busy       (busy),
      .pc_upd     (pc_upd),
      .pc_upd_val (pc_upd_val),
      .pop_data   (pop_data),
      .pop_valid  (pop_valid)
   );

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         pc <= PC_RST;
      end else if (pc_upd) begin
         pc <= pc_upd_val;
      end else if (accept && !uses_stack(cls)) begin
         pc <= next_pc;
      end
   end

endmodule

// File: rtl/pc_stack_seq_chk.sv
module pc_stack_seq_chk #(
   parameter int DW    = 8,
   parameter int PC_W  = 16,
   parameter int SP_W  = 8
) (
   input logic            clk,
   input logic            rst_n,
   input logic            start,
   input logic            ram_we,
   input logic            ram_re,
   input logic [SP_W-1:0] ram_addr,
   input logic [PC_W-1:0] pc,
   input logic [SP_W-1:0] sp,
   input logic            busy,
   input logic            pop_valid
);

   // R13: the RAM port never reads and writes at once
   p_excl_access_r13: assert property (@(posedge clk) disable iff (!rst_n)
      !(ram_we && ram_re));

   // R13: no RAM traffic outside a busy sequence
   p_idle_quiet_r13: assert property (@(posedge clk) disable iff (!rst_n)
      !busy |-> (!ram_we && !ram_re));

   // R11: program counter frozen between busy cycles
   p_pc_hold_r11: assert property (@(posedge clk) disable iff (!rst_n)
      (busy && $past(busy)) |-> $stable(pc));

   // R11: stack pointer moves only on the edge that ends a sequence
   p_sp_hold_r11: assert property (@(posedge clk) disable iff (!rst_n)
      !$past(busy) |-> $stable(sp));

   // R7: a call writes the return address low byte first, upward
   p_call_order_r7: assert property (@(posedge clk) disable iff (!rst_n)
      (ram_we && $past(ram_we)) |-> (ram_addr == $past(ram_addr) + SP_W'(1)));

   // R8: a return reads downward from the top of stack
   p_ret_order_r8: assert property (@(posedge clk) disable iff (!rst_n)
      (ram_re && $past(ram_re)) |-> (ram_addr == $past(ram_addr) - SP_W'(1)));

   // R10: pop result is announced once the sequence has ended
   p_pop_pulse_r10: assert property (@(posedge clk) disable iff (!rst_n)
      pop_valid |-> (!busy && !$past(pop_valid)));

endmodule

bind pc_stack_seq pc_stack_seq_chk #(
   .DW   (DW),
   .PC_W (PC_W),
   .SP_W (SP_W)
) u_chk (
   .clk       (clk),
   .rst_n     (rst_n),
   .start     (start),
   .ram_we    (ram_we),
   .ram_re    (ram_re),
   .ram_addr  (ram_addr),
   .pc        (pc),
   .sp        (sp),
   .busy      (busy),
   .pop_valid (pop_valid)
);

// File: tb/pc_stack_seq_test.sv
module pc_stack_seq_test;

   localparam int CLK_PERIOD = 10;
   localparam int WATCHDOG   = 20000;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        start = 1'b0;
   logic [3:0]  op_class = '0;
   logic [1:0]  instr_len = '0;
   logic [7:0]  rel_off = '0;
   logic [10:0] abs_addr11 = '0;
   logic [15:0] abs_addr16 = '0;
   logic        taken = 1'b0;
   logic [7:0]  acc = '0;
   logic [15:0] dptr = '0;
   logic [7:0]  push_data = '0;
   logic [7:0]  ram_rdata;
   logic        ram_we, ram_re;
   logic [7:0]  ram_addr, ram_wdata;
   logic [15:0] pc;
   logic [7:0]  sp;
   logic        busy;
   logic [7:0]  pop_data;
   logic        pop_valid;

   int checks = 0;
   int fails  = 0;

   logic [7:0] mem [256];

   always #(CLK_PERIOD/2) clk = ~clk;

   always @(posedge clk) begin
      if (ram_we) mem[ram_addr] <= ram_wdata;
      if (ram_re) ram_rdata <= mem[ram_addr];
   end

   pc_stack_seq uut (
      .clk(clk), .rst_n(rst_n), .start(start), .op_class(op_class),
      .instr_len(instr_len), .rel_off(rel_off), .abs_addr11(abs_addr11),
      .abs_addr16(abs_addr16), .taken(taken), .acc(acc), .dptr(dptr),
      .push_data(push_data), .ram_rdata(ram_rdata), .ram_we(ram_we),
      .ram_re(ram_re), .ram_addr(ram_addr), .ram_wdata(ram_wdata),
      .pc(pc), .sp(sp), .busy(busy), .pop_data(pop_data), .pop_valid(pop_valid)
   );

   typedef struct packed {
      logic [3:0]  c;
      logic [1:0]  l;
      logic [7:0]  off;
      logic [10:0] a11;
      logic [15:0] a16;
      logic        t;
      logic [7:0]  a;
      logic [15:0] d;
      logic [15:0] exp_pc;
   } vec_t;

   localparam int NV = 16;
   localparam vec_t VEC [NV] = '{
      '{4'd3, 2'd3, 8'h00, 11'h000, 16'h1234, 1'b0, 8'h00, 16'h0000, 16'h1234},
      '{4'd0, 2'd1, 8'h00, 11'h000, 16'h0000, 1'b0, 8'h00, 16'h0000, 16'h1235},
      '{4'd0, 2'd3, 8'h00, 11'h000, 16'h0000, 1'b0, 8'h00, 16'h0000, 16'h1238},
      '{4'd1, 2'd2, 8'h10, 11'h000, 16'h0000, 1'b0, 8'h00, 16'h0000, 16'h124A},
      '{4'd1, 2'd2, 8'hF0, 11'h000, 16'h0000, 1'b0, 8'h00, 16'h0000, 16'h123C},
      '{4'd5, 2'd3, 8'h05, 11'h000, 16'h0000, 1'b1, 8'h00, 16'h0000, 16'h1244},
      '{4'd5, 2'd3, 8'h05, 11'h000, 16'h0000, 1'b0, 8'h00, 16'h0000, 16'h1247},
      '{4'd5, 2'd2, 8'h80, 11'h000, 16'h0000, 1'b1, 8'h00, 16'h0000, 16'h11C9},
      '{4'd2, 2'd2, 8'h00, 11'h7FF, 16'h0000, 1'b0, 8'h00, 16'h0000, 16'h17FF},
      '{4'd4, 2'd1, 8'h00, 11'h000, 16'h0000, 1'b0, 8'h34, 16'h2000, 16'h2034},
      '{4'd4, 2'd1, 8'h00, 11'h000, 16'h0000, 1'b0, 8'h20, 16'hFFF0, 16'h0010},
      '{4'd1, 2'd2, 8'hFD, 11'h000, 16'h0000, 1'b0, 8'h00, 16'h0000, 16'h000F},
      '{4'd1, 2'd2, 8'h80, 11'h000, 16'h0000, 1'b0, 8'h00, 16'h0000, 16'hFF91},
      '{4'd3, 2'd3, 8'h00, 11'h000, 16'hFFFF, 1'b0, 8'h00, 16'h0000, 16'hFFFF},
      '{4'd0, 2'd1, 8'h00, 11'h000, 16'h0000, 1'b0, 8'h00, 16'h0000, 16'h0000},
      '{4'd2, 2'd2, 8'h00, 11'h123, 16'h0000, 1'b0, 8'h00, 16'h0000, 16'h0123}
   };

   function automatic string req_of(input logic [3:0] c);
      case (c)
         4'd0:       return "R2";
         4'd1, 4'd5: return "R3";
         4'd2:       return "R4";
         4'd3:       return "R5";
         default:    return "R6";
      endcase
   endfunction

   task automatic check(input string req, input logic [15:0] act, input logic [15:0] exp);
      checks++;
      if (act !== exp) begin
         fails++;
         $display("FAIL %s: actual %h expected %h", req, act, exp);
      end
   endtask

   task automatic issue(input logic [3:0] c, input logic [1:0] l, input logic [7:0] off,
                        input logic [10:0] a11, input logic [15:0] a16, input logic t,
                        input logic [7:0] a, input logic [15:0] d, input logic [7:0] pd,
                        output int bcyc);
      @(negedge clk);
      op_class = c; instr_len = l; rel_off = off; abs_addr11 = a11;
      abs_addr16 = a16; taken = t; acc = a; dptr = d; push_data = pd;
      start = 1'b1;
      @(negedge clk);
      start = 1'b0;
      bcyc = 0;
      while (busy && bcyc < 50) begin
         @(negedge clk);
         bcyc++;
      end
   endtask

   initial begin
      repeat (WATCHDOG) @(posedge clk);
      fails++;
      checks++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("%0d/%0d checks passed", checks - fails, checks);
      $finish;
   end

   initial begin
      int bc;
      for (int i = 0; i < 256; i++) mem[i] = 8'h00;
      rst_n = 1'b0;
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);
      // R1 reset state
      check("R1 pc", pc, 16'h0000);
      check("R1 sp", {8'h00, sp}, 16'h0007);
      check("R1 busy", {15'd0, busy}, 16'h0000);
      check("R1 ram strobes", {14'd0, ram_we, ram_re}, 16'h0000);

      // table of jump vectors, each result chained into the next
      for (int i = 0; i < NV; i++) begin
         issue(VEC[i].c, VEC[i].l, VEC[i].off, VEC[i].a11, VEC[i].a16,
               VEC[i].t, VEC[i].a, VEC[i].d, 8'h00, bc);
         check(req_of(VEC[i].c), pc, VEC[i].exp_pc);
      end
      check("R11 sp untouched by jumps", {8'h00, sp}, 16'h0007);

      // R9 push pre-increments and writes
      issue(4'd9, 2'd2, 8'h00, 11'h0, 16'h0, 1'b0, 8'h0, 16'h0, 8'hA5, bc);
      check("R9 busy cycles", 16'(bc), 16'd1);
      check("R9 sp", {8'h00, sp}, 16'h0008);
      check("R9 ram[08]", {8'h00, mem[8'h08]}, 16'h00A5);
      check("R9 pc", pc, 16'h0125);

      issue(4'd3, 2'd3, 8'h00, 11'h0, 16'h4321, 1'b0, 8'h0, 16'h0, 8'h0, bc);
      // R7 long call
      issue(4'd7, 2'd3, 8'h00, 11'h0, 16'h8000, 1'b0, 8'h0, 16'h0, 8'h0, bc);
      check("R7 busy cycles", 16'(bc), 16'd2);
      check("R7 low byte at sp+1", {8'h00, mem[8'h09]}, 16'h0024);
      check("R7 high byte at sp+2", {8'h00, mem[8'h0A]}, 16'h0043);
      check("R7 sp", {8'h00, sp}, 16'h000A);
      check("R7 pc", pc, 16'h8000);
      // R7 short call, keeps upper five pc bits
      issue(4'd6, 2'd2, 8'h00, 11'h055, 16'h0, 1'b0, 8'h0, 16'h0, 8'h0, bc);
      check("R7 short low byte", {8'h00, mem[8'h0B]}, 16'h0002);
      check("R7 short high byte", {8'h00, mem[8'h0C]}, 16'h0080);
      check("R7 short sp", {8'h00, sp}, 16'h000C);
      check("R7 short pc", pc, 16'h8055);

      // R8 nested returns
      issue(4'd8, 2'd1, 8'h00, 11'h0, 16'h0, 1'b0, 8'h0, 16'h0, 8'h0, bc);
      check("R8 busy cycles", 16'(bc), 16'd3);
      check("R8 pc", pc, 16'h8002);
      check("R8 sp", {8'h00, sp}, 16'h000A);
      issue(4'd8, 2'd1, 8'h00, 11'h0, 16'h0, 1'b0, 8'h0, 16'h0, 8'h0, bc);
      check("R8 outer pc", pc, 16'h4324);
      check("R8 outer sp", {8'h00, sp}, 16'h0008);

      // R10 pop
      issue(4'd10, 2'd2, 8'h00, 11'h0, 16'h0, 1'b0, 8'h0, 16'h0, 8'h0, bc);
      check("R10 busy cycles", 16'(bc), 16'd2);
      check("R10 pop_valid", {15'd0, pop_valid}, 16'h0001);
      check("R10 pop_data", {8'h00, pop_data}, 16'h00A5);
      check("R10 sp", {8'h00, sp}, 16'h0007);
      check("R10 pc", pc, 16'h4326);
      @(negedge clk);
      check("R10 pop_valid one cycle", {15'd0, pop_valid}, 16'h0000);

      // R11 start raised during a push is ignored
      @(negedge clk);
      op_class = 4'd9; instr_len = 2'd1; push_data = 8'h5A; start = 1'b1;
      @(negedge clk);
      check("R11 busy during push", {15'd0, busy}, 16'h0001);
      op_class = 4'd3; abs_addr16 = 16'hDEAD;
      @(negedge clk);
      start = 1'b0;
      @(negedge clk);
      check("R11 pc after ignored start", pc, 16'h4327);
      check("R11 sp after ignored start", {8'h00, sp}, 16'h0008);
      check("R11 pushed byte", {8'h00, mem[8'h08]}, 16'h005A);

      // R12 pointer wraps below zero and back
      for (int k = 0; k < 9; k++)
         issue(4'd10, 2'd1, 8'h00, 11'h0, 16'h0, 1'b0, 8'h0, 16'h0, 8'h0, bc);
      check("R12 sp wrap down", {8'h00, sp}, 16'h00FF);
      issue(4'd9, 2'd1, 8'h00, 11'h0, 16'h0, 1'b0, 8'h0, 16'h0, 8'h77, bc);
      check("R12 sp wrap up", {8'h00, sp}, 16'h0000);
      check("R12 push at 00", {8'h00, mem[8'h00]}, 16'h0077);
      check("R13 idle strobes", {14'd0, ram_we, ram_re}, 16'h0000);

      $display("%0d/%0d checks passed", checks - fails, checks);
      $finish;
   end

endmodule